// File: doc/BRIEF.md
# Four-Bank SDRAM Command Sequencer

This block sits between a memory controller's scheduler and the SDRAM command pins. It follows the state of four independent banks and, for the command presented in the current cycle, returns one verdict. The command may be taken now. It may be legal but too early, and must be held. Or it is illegal in the present bank state. Taken commands update the bank state and load per-bank and shared down-counters. These counters enforce the minimum command spacing in clock cycles, which depends on the programmed burst length and CAS latency.

The verdict is combinational on the present inputs. The scheduler keeps the command on its inputs while the block reports a stall and drops it when the block flags it illegal. Reads and writes with the auto-precharge flag close their bank by themselves once the burst and recovery time have run out. The row-to-column, precharge, row-cycle, write-recovery and write-to-read times are parameters given in clock cycles.

Top module: `sdramCmdSeq`

## Requirements
- R1: After reset every bank is idle, and a no-operation (code 0) is accepted. Bank b is reported in bankState[2b+1:2b], encoded 00 idle, 01 active and 10 precharging. Command codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop, 6 refresh and 7 mode-register set.
- R2: In every cycle exactly one of cmdAccept, cmdStall and cmdIllegal is high for the present inputs.
- R3: Activate to an active bank is illegal. Activate to a precharging bank, or sooner than T_RC cycles after the previous activate of that bank, stalls. Otherwise it is accepted, and the bank reads active in the next cycle.
- R4: Read or write to a bank that is not active is illegal. Sooner than T_RCD cycles after that bank's activate, it stalls.
- R5: Precharge of one bank (autoPre low) is illegal sooner than BL/2 cycles after a read, or BL/2+T_WR cycles after a write, to that bank. An accepted precharge of an active bank makes the bank precharging for T_RP cycles, after which it is idle. Precharge of an idle bank is accepted and has no effect.
- R6: Precharge with autoPre high closes every active bank at once. It is illegal while any active bank is still in recovery.
- R7: A read stalls until BL/2+T_WTR cycles after the last accepted write to any bank.
- R8: A write stalls until CL+BL/2 cycles after the last accepted read, or CL cycles after an accepted burst stop.
- R9: Burst stop is accepted only during the BL/2 cycles that follow an accepted read. At any other time it is illegal.
- R10: A read or write with autoPre high puts its bank into precharging in the cycle after its recovery ends, with no further command. Until then, read, write and precharge to that bank are illegal.
- R11: Refresh and mode-register set are accepted only while all banks are idle, and are illegal otherwise. Codes 8 to 15 are always illegal.
- R12: A command flagged illegal changes no bank state.
- R13: Burst-length code blCode selects BL: 1 gives 2, 2 gives 4, 3 gives 8, and 0 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdCode | input | 4 | Command presented this cycle |
| bankSel | input | 2 | Target bank |
| autoPre | input | 1 | Auto-precharge on read/write; all banks on precharge |
| blCode | input | 2 | Programmed burst-length code |
| casLat | input | 3 | Programmed CAS latency in whole cycles |
| cmdAccept | output | 1 | Command taken this cycle |
| cmdStall | output | 1 | Command legal but must be held |
| cmdIllegal | output | 1 | Command not allowed in present state |
| bankState | output | 8 | Two-bit state per bank |

## Verification
The assertions assume that a stalled command is either retried or replaced. They also assume that blCode and casLat change only while no read or write burst is in flight, since the counters were loaded from the old values. The spacing checks further assume T_RCD stays below 255. The stimulus changes the burst-length code only after every bank has returned to idle and all recovery has expired. It keeps the timing parameters at small defaults, and every command it issues is a single-cycle decision sampled before the clock edge.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W = $clog2(NUM_BANKS);

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_READ = 4'd2,
    CMD_WRIT = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_BST  = 4'd5,
    CMD_REF  = 4'd6,
    CMD_MRS  = 4'd7
  } cmdE;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_PRECHG = 2'd2
  } bankStE;

  typedef struct packed {
    logic [NUM_BANKS-1:0] act;
    logic [NUM_BANKS-1:0] pre;
    logic [NUM_BANKS-1:0] rd;
    logic [NUM_BANKS-1:0] wr;
    logic                 ap;
    logic                 bst;
  } strobeT;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
(
  input  logic [3:0]                 cmdCode,
  input  logic [BANK_W-1:0]          bankSel,
  input  logic                       autoPre,
  input  logic [NUM_BANKS-1:0][1:0]  bankSt,
  input  logic [NUM_BANKS-1:0]       rcdOk,
  input  logic [NUM_BANKS-1:0]       rcOk,
  input  logic [NUM_BANKS-1:0]       recovOk,
  input  logic [NUM_BANKS-1:0]       apPend,
  input  logic                       wtrOk,
  input  logic                       rdWrOk,
  input  logic                       burstOn,
  output logic                       accept,
  output logic                       stall,
  output logic                       illegal,
  output strobeT                     strb
);
  logic [NUM_BANKS-1:0] selMask;
  logic [NUM_BANKS-1:0] activeMask;
  logic [NUM_BANKS-1:0] busyMask;
  logic                 allIdle;
  logic [1:0]           selSt;
  logic                 legal;
  logic                 hold;

  always_comb begin
    selMask = NUM_BANKS'(1) << bankSel;
    allIdle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      activeMask[b] = (bankSt[b] == BK_ACTIVE);
      if (bankSt[b] != BK_IDLE) allIdle = 1'b0;
    end
    busyMask = activeMask & (~recovOk | apPend);
    selSt = bankSt[bankSel];
  end

  always_comb begin
    legal = 1'b0;
    hold  = 1'b0;
    case (cmdCode)
      CMD_NOP: legal = 1'b1;
      CMD_ACT: begin
        legal = (selSt != BK_ACTIVE);
        hold  = (selSt == BK_PRECHG) || !rcOk[bankSel];
      end
      CMD_READ: begin
        legal = (selSt == BK_ACTIVE) && !apPend[bankSel];
        hold  = !rcdOk[bankSel] || !wtrOk;
      end
      CMD_WRIT: begin
        legal = (selSt == BK_ACTIVE) && !apPend[bankSel];
        hold  = !rcdOk[bankSel] || !rdWrOk;
      end
      CMD_PRE: legal = autoPre ? (busyMask == '0) : !busyMask[bankSel];
      CMD_BST: legal = burstOn;
      CMD_REF, CMD_MRS: legal = allIdle;
      default: legal = 1'b0;
    endcase
    accept  = legal && !hold;
    stall   = legal && hold;
    illegal = !legal;
  end

  always_comb begin
    strb = '0;
    if (accept) begin
      case (cmdCode)
        CMD_ACT:  strb.act = selMask;
        CMD_READ: begin strb.rd = selMask; strb.ap = autoPre; end
        CMD_WRIT: begin strb.wr = selMask; strb.ap = autoPre; end
        CMD_PRE:  strb.pre = autoPre ? activeMask : (selMask & activeMask);
        CMD_BST:  strb.bst = 1'b1;
        default:  strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/seqPath.sv
module seqPath
  import seqPkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 8,
  parameter int T_WR  = 2,
  parameter int T_WTR = 1,
  parameter int CNT_W = 6,
  parameter int CL_W  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     strb,
  input  logic [1:0]                 blCode,
  input  logic [CL_W-1:0]            casLat,
  output logic [NUM_BANKS-1:0][1:0]  bankSt,
  output logic [NUM_BANKS-1:0]       rcdOk,
  output logic [NUM_BANKS-1:0]       rcOk,
  output logic [NUM_BANKS-1:0]       recovOk,
  output logic [NUM_BANKS-1:0]       apPend,
  output logic                       wtrOk,
  output logic                       rdWrOk,
  output logic                       burstOn
);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'((T_RCD > 0) ? T_RCD - 1 : 0);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'((T_RP  > 0) ? T_RP  - 1 : 0);
  localparam logic [CNT_W-1:0] RC_LD  = CNT_W'((T_RC  > 0) ? T_RC  - 1 : 0);
  localparam logic [CNT_W-1:0] WR_ADD = CNT_W'(T_WR);
  localparam logic [CNT_W-1:0] WTR_ADD = CNT_W'(T_WTR);

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  logic [CNT_W-1:0] halfBurst;
  logic [CNT_W-1:0] clCnt;
  logic [CNT_W-1:0] wtrCnt, rdWrCnt, readLeft;
  logic             anyRd, anyWr;

  always_comb begin
    case (blCode)
      2'd2:    halfBurst = CNT_W'(2);
      2'd3:    halfBurst = CNT_W'(4);
      default: halfBurst = CNT_W'(1);
    endcase
    clCnt = CNT_W'(casLat);
    anyRd = |strb.rd;
    anyWr = |strb.wr;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] rcdCnt, rcCnt, recCnt, rpCnt, recLoad, recDec;
    logic [1:0]       st;
    logic             apQ;

    always_comb begin
      if (strb.wr[b])      recLoad = halfBurst + WR_ADD - 1'b1;
      else if (strb.rd[b]) recLoad = halfBurst - 1'b1;
      else                 recLoad = '0;
      recDec = dec(recCnt);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st     <= BK_IDLE;
        rcdCnt <= '0;
        rcCnt  <= '0;
        recCnt <= '0;
        rpCnt  <= '0;
        apQ    <= 1'b0;
      end else begin
        rcdCnt <= strb.act[b] ? RCD_LD : dec(rcdCnt);
        rcCnt  <= strb.act[b] ? RC_LD  : dec(rcCnt);
        recCnt <= (recLoad > recDec) ? recLoad : recDec;
        if (strb.pre[b]) begin
          st    <= BK_PRECHG;
          rpCnt <= RP_LD;
          apQ   <= 1'b0;
        end else if (strb.act[b]) begin
          st <= BK_ACTIVE;
        end else if (st == BK_ACTIVE && apQ && recCnt == '0) begin
          st    <= BK_PRECHG;
          rpCnt <= RP_LD;
          apQ   <= 1'b0;
        end else if (st == BK_PRECHG) begin
          if (rpCnt == '0) st <= BK_IDLE;
          else             rpCnt <= rpCnt - 1'b1;
        end
        if ((strb.rd[b] || strb.wr[b]) && strb.ap) apQ <= 1'b1;
      end
    end

    assign bankSt[b]  = st;
    assign rcdOk[b]   = (rcdCnt == '0);
    assign rcOk[b]    = (rcCnt == '0);
    assign recovOk[b] = (recCnt == '0);
    assign apPend[b]  = apQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wtrCnt   <= '0;
      rdWrCnt  <= '0;
      readLeft <= '0;
    end else begin
      wtrCnt <= anyWr ? (halfBurst + WTR_ADD - 1'b1) : dec(wtrCnt);
      if (anyRd) begin
        rdWrCnt  <= halfBurst + clCnt - 1'b1;
        readLeft <= halfBurst;
      end else if (strb.bst) begin
        rdWrCnt  <= dec(clCnt);
        readLeft <= '0;
      end else begin
        rdWrCnt  <= dec(rdWrCnt);
        readLeft <= dec(readLeft);
      end
    end
  end

  assign wtrOk   = (wtrCnt == '0);
  assign rdWrOk  = (rdWrCnt == '0);
  assign burstOn = (readLeft != '0);
endmodule

// File: rtl/sdramCmdSeq.sv
module sdramCmdSeq
  import seqPkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 8,
  parameter int T_WR  = 2,
  parameter int T_WTR = 1,
  parameter int CNT_W = 6,
  parameter int CL_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [3:0]               cmdCode,
  input  logic [1:0]               bankSel,
  input  logic                     autoPre,
  input  logic [1:0]               blCode,
  input  logic [2:0]               casLat,
  output logic                     cmdAccept,
  output logic                     cmdStall,
  output logic                     cmdIllegal,
  output logic [7:0]               bankState
);
  strobeT                     strb;
  logic [NUM_BANKS-1:0][1:0]  bankSt;
  logic [NUM_BANKS-1:0]       rcdOk, rcOk, recovOk, apPend;
  logic                       wtrOk, rdWrOk, burstOn;

  seqCtrl u_ctrl (
    .cmdCode (cmdCode),
    .bankSel (bankSel),
    .autoPre (autoPre),
    .bankSt  (bankSt),
    .rcdOk   (rcdOk),
    .rcOk    (rcOk),
    .recovOk (recovOk),
    .apPend  (apPend),
    .wtrOk   (wtrOk),
    .rdWrOk  (rdWrOk),
    .burstOn (burstOn),
    .accept  (cmdAccept),
    .stall   (cmdStall),
    .illegal (cmdIllegal),
    .strb    (strb)
  );

  seqPath #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_WR(T_WR),
    .T_WTR(T_WTR), .CNT_W(CNT_W), .CL_W(CL_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .blCode  (blCode),
    .casLat  (casLat),
    .bankSt  (bankSt),
    .rcdOk   (rcdOk),
    .rcOk    (rcOk),
    .recovOk (recovOk),
    .apPend  (apPend),
    .wtrOk   (wtrOk),
    .rdWrOk  (rdWrOk),
    .burstOn (burstOn)
  );

  assign bankState = bankSt;
endmodule

// File: rtl/sdramCmdSeqCheck.sv
module sdramCmdSeqCheck #(
  parameter int T_RCD = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] cmdCode,
  input logic [1:0] bankSel,
  input logic       autoPre,
  input logic       cmdAccept,
  input logic       cmdStall,
  input logic       cmdIllegal,
  input logic [7:0] bankState,
  input logic [3:0] apPend
);
  function automatic logic [1:0] stOf(input logic [7:0] v, input logic [1:0] i);
    return v[2*i +: 2];
  endfunction

  logic [7:0] sinceAct [4];
  logic       anyPrechg;

  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (!rstN) sinceAct[b] <= 8'hFF;
      else if (cmdAccept && cmdCode == 4'd1 && bankSel == 2'(b)) sinceAct[b] <= 8'd1;
      else if (sinceAct[b] != 8'hFF) sinceAct[b] <= sinceAct[b] + 8'd1;
    end
  end

  always_comb begin
    anyPrechg = 1'b0;
    for (int b = 0; b < 4; b++)
      if (bankState[2*b +: 2] == 2'd2) anyPrechg = 1'b1;
  end

  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({cmdAccept, cmdStall, cmdIllegal}));

  p_act_opens_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAccept && cmdCode == 4'd1) |=> stOf(bankState, $past(bankSel)) == 2'd1);

  p_act_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == 4'd1 && stOf(bankState, bankSel) == 2'd1) |-> cmdIllegal);

  p_rw_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAccept && (cmdCode == 4'd2 || cmdCode == 4'd3)) |-> stOf(bankState, bankSel) == 2'd1);

  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAccept && (cmdCode == 4'd2 || cmdCode == 4'd3)) |-> sinceAct[bankSel] >= 8'(T_RCD));

  p_pre_closes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAccept && cmdCode == 4'd4 && !autoPre && stOf(bankState, bankSel) == 2'd1)
      |=> stOf(bankState, $past(bankSel)) == 2'd2);

  p_ref_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAccept && (cmdCode == 4'd6 || cmdCode == 4'd7)) |-> bankState == 8'h00);

  p_bad_code_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode[3] |-> cmdIllegal);

  p_illegal_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIllegal && !anyPrechg && apPend == 4'b0) |=> $stable(bankState));
endmodule

bind sdramCmdSeq sdramCmdSeqCheck #(.T_RCD(T_RCD)) u_check (
  .clk        (clk),
  .rstN       (rstN),
  .cmdCode    (cmdCode),
  .bankSel    (bankSel),
  .autoPre    (autoPre),
  .cmdAccept  (cmdAccept),
  .cmdStall   (cmdStall),
  .cmdIllegal (cmdIllegal),
  .bankState  (bankState),
  .apPend     (apPend)
);

// File: tb/sdramCmdSeq_bench.sv
module sdramCmdSeq_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cmdCode = 4'd0;
  logic [1:0] bankSel = 2'd0;
  logic       autoPre = 1'b0;
  logic [1:0] blCode = 2'd2;
  logic [2:0] casLat = 3'd2;
  logic       cmdAccept, cmdStall, cmdIllegal;
  logic [7:0] bankState;

  int checks = 0;
  int errors = 0;

  sdramCmdSeq u_sdramCmdSeq (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .bankSel(bankSel),
    .autoPre(autoPre), .blCode(blCode), .casLat(casLat),
    .cmdAccept(cmdAccept), .cmdStall(cmdStall), .cmdIllegal(cmdIllegal),
    .bankState(bankState)
  );

  always #4 clk = ~clk;

  // Verdict codes: 0 accept, 1 stall, 2 illegal.
  // Entry: {req, cmd, bank, autoPre, verdict, stateAfter}. BL4, CL2.
  localparam int NV = 29;
  localparam logic [20:0] VEC [NV] = '{
    {4'd1,  4'd0, 2'd0, 1'b0, 2'd0, 8'h00},  // R1 no-op accepted
    {4'd4,  4'd2, 2'd0, 1'b0, 2'd2, 8'h00},  // R4 read to idle bank
    {4'd3,  4'd1, 2'd0, 1'b0, 2'd0, 8'h01},  // R3 activate bank 0
    {4'd12, 4'd1, 2'd0, 1'b0, 2'd2, 8'h01},  // R12 R3 second activate illegal
    {4'd4,  4'd2, 2'd0, 1'b0, 2'd1, 8'h01},  // R4 tRCD not met
    {4'd4,  4'd2, 2'd0, 1'b0, 2'd0, 8'h01},  // R4 read taken
    {4'd5,  4'd4, 2'd0, 1'b0, 2'd2, 8'h01},  // R5 precharge too soon
    {4'd9,  4'd5, 2'd0, 1'b0, 2'd0, 8'h01},  // R9 burst stop during read
    {4'd8,  4'd3, 2'd0, 1'b0, 2'd1, 8'h01},  // R8 CL after stop
    {4'd8,  4'd3, 2'd0, 1'b0, 2'd0, 8'h01},  // R8 write taken
    {4'd7,  4'd2, 2'd0, 1'b0, 2'd1, 8'h01},  // R7 write-to-read
    {4'd7,  4'd2, 2'd0, 1'b0, 2'd1, 8'h01},  // R7
    {4'd10, 4'd2, 2'd0, 1'b1, 2'd0, 8'h01},  // R10 read with auto precharge
    {4'd10, 4'd4, 2'd0, 1'b0, 2'd2, 8'h01},  // R10 precharge while pending
    {4'd10, 4'd0, 2'd0, 1'b0, 2'd0, 8'h02},  // R10 bank closes itself
    {4'd3,  4'd1, 2'd0, 1'b0, 2'd1, 8'h02},  // R3 activate while precharging
    {4'd5,  4'd0, 2'd0, 1'b0, 2'd0, 8'h02},  // R5 tRP running
    {4'd5,  4'd0, 2'd0, 1'b0, 2'd0, 8'h00},  // R5 idle after tRP
    {4'd3,  4'd1, 2'd1, 1'b0, 2'd0, 8'h04},  // R3 bank 1
    {4'd3,  4'd1, 2'd2, 1'b0, 2'd0, 8'h14},  // R3 bank 2
    {4'd11, 4'd6, 2'd0, 1'b0, 2'd2, 8'h14},  // R11 refresh with open banks
    {4'd6,  4'd4, 2'd0, 1'b1, 2'd0, 8'h28},  // R6 precharge all
    {4'd11, 4'd7, 2'd0, 1'b0, 2'd2, 8'h28},  // R11 mode set while precharging
    {4'd6,  4'd0, 2'd0, 1'b0, 2'd0, 8'h28},  // R6
    {4'd6,  4'd0, 2'd0, 1'b0, 2'd0, 8'h00},  // R6 all idle
    {4'd11, 4'd7, 2'd0, 1'b0, 2'd0, 8'h00},  // R11 mode set accepted
    {4'd11, 4'd9, 2'd0, 1'b0, 2'd2, 8'h00},  // R11 unknown code
    {4'd5,  4'd4, 2'd3, 1'b0, 2'd0, 8'h00},  // R5 precharge idle bank
    {4'd9,  4'd5, 2'd0, 1'b0, 2'd2, 8'h00}   // R9 stop with no burst
  };

  function automatic logic [1:0] verdict();
    if (cmdAccept && !cmdStall && !cmdIllegal) return 2'd0;
    if (cmdStall && !cmdAccept && !cmdIllegal) return 2'd1;
    if (cmdIllegal && !cmdAccept && !cmdStall) return 2'd2;
    return 2'd3;
  endfunction

  task automatic step(input logic [3:0] c, input logic [1:0] b, input logic ap,
                      input logic [1:0] expV, input logic [7:0] expS, input int req);
    logic [1:0] gotV;
    @(negedge clk);
    cmdCode = c; bankSel = b; autoPre = ap;
    #1;
    gotV = verdict();
    checks++;
    if (gotV !== expV) begin
      errors++;
      $display("FAIL R%0d verdict cmd=%0d bank=%0d: got %0d expected %0d", req, c, b, gotV, expV);
    end
    @(posedge clk);
    #1;
    checks++;
    if (bankState !== expS) begin
      errors++;
      $display("FAIL R%0d state after cmd=%0d: got %h expected %h", req, c, bankState, expS);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checks++;
    if (bankState !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset state: got %h expected 00", bankState);
    end

    for (int i = 0; i < NV; i++)
      step(VEC[i][16:13], VEC[i][12:11], VEC[i][10], VEC[i][9:8], VEC[i][7:0], int'(VEC[i][20:17]));

    // R3 row-cycle stall, bank 0
    step(4'd1, 2'd0, 1'b0, 2'd0, 8'h01, 3);
    step(4'd0, 2'd0, 1'b0, 2'd0, 8'h01, 3);
    step(4'd0, 2'd0, 1'b0, 2'd0, 8'h01, 3);
    step(4'd4, 2'd0, 1'b0, 2'd0, 8'h02, 5);
    step(4'd0, 2'd0, 1'b0, 2'd0, 8'h02, 5);
    step(4'd0, 2'd0, 1'b0, 2'd0, 8'h02, 5);
    step(4'd0, 2'd0, 1'b0, 2'd0, 8'h00, 5);
    step(4'd1, 2'd0, 1'b0, 2'd1, 8'h00, 3);  // R3 tRC not met
    step(4'd1, 2'd0, 1'b0, 2'd0, 8'h01, 3);
    step(4'd4, 2'd0, 1'b0, 2'd0, 8'h02, 5);
    step(4'd0, 2'd0, 1'b0, 2'd0, 8'h02, 5);
    step(4'd0, 2'd0, 1'b0, 2'd0, 8'h02, 5);
    step(4'd0, 2'd0, 1'b0, 2'd0, 8'h00, 5);

    // R13 R10 write with auto precharge at BL8, bank 1
    blCode = 2'd3;
    step(4'd1, 2'd1, 1'b0, 2'd0, 8'h04, 10);
    step(4'd0, 2'd1, 1'b0, 2'd0, 8'h04, 10);
    step(4'd0, 2'd1, 1'b0, 2'd0, 8'h04, 10);
    step(4'd3, 2'd1, 1'b1, 2'd0, 8'h04, 10);
    step(4'd0, 2'd1, 1'b0, 2'd0, 8'h04, 10);
    step(4'd3, 2'd1, 1'b0, 2'd2, 8'h04, 10);  // R10 write while pending
    step(4'd2, 2'd1, 1'b0, 2'd2, 8'h04, 10);  // R10 read while pending
    step(4'd0, 2'd1, 1'b0, 2'd0, 8'h04, 13);
    step(4'd0, 2'd1, 1'b0, 2'd0, 8'h04, 13);
    step(4'd0, 2'd1, 1'b0, 2'd0, 8'h08, 13);  // R13 BL8 recovery end
    step(4'd0, 2'd1, 1'b0, 2'd0, 8'h08, 5);
    step(4'd0, 2'd1, 1'b0, 2'd0, 8'h08, 5);
    step(4'd0, 2'd1, 1'b0, 2'd0, 8'h00, 5);

    // R13 R9 BL2 burst window, bank 2
    blCode = 2'd1;
    step(4'd1, 2'd2, 1'b0, 2'd0, 8'h10, 13);
    step(4'd0, 2'd2, 1'b0, 2'd0, 8'h10, 13);
    step(4'd0, 2'd2, 1'b0, 2'd0, 8'h10, 13);
    step(4'd2, 2'd2, 1'b0, 2'd0, 8'h10, 13);
    step(4'd0, 2'd2, 1'b0, 2'd0, 8'h10, 13);
    step(4'd5, 2'd2, 1'b0, 2'd2, 8'h10, 9);   // R9 window of one cycle over
    step(4'd4, 2'd2, 1'b0, 2'd0, 8'h20, 5);

    // R1 reset mid-activity
    @(negedge clk);
    cmdCode = 4'd0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (bankState !== 8'h00 || verdict() !== 2'd0) begin
      errors++;
      $display("FAIL R1 after reset: got state %h verdict %0d expected 00 0", bankState, verdict());
    end
    step(4'd2, 2'd2, 1'b0, 2'd2, 8'h00, 1);  // R1 bank closed by reset

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule